// File: doc/BRIEF.md
# Transfer Address and Position Updater

This block produces the register values a disk controller writes back once a data transfer has finished. It receives the starting memory address, split into a 16-bit bus-address word and two extension bits. It also takes the word-count register, which holds the two's complement of the requested length, the packed disk address (drive, track, sector) and the number of words the data path actually moved. From these it returns the updated word count, the advanced memory address and a disk address that points at the sector following the transfer.

A transfer is clipped at the end of the drive. When the requested length runs past the last word of the drive, the usable length is cut to the remaining room and an overrun flag is raised. Two mode inputs change how addresses advance. Increment-inhibit keeps the memory address fixed. Format-read advances the disk position by one whole sector per word. The block is sequential: one start strobe loads the operands, and after a fixed number of cycles a one-cycle done pulse marks the results valid. Packing the new track and sector needs a division by the sectors-per-track count. A parameter chooses between a bit-serial divider and a single-cycle direct divider.

Top module: `xfer_pos_updater`

## Requirements
- R1: While reset is held and after it is released, done_o, busy_o, overrun_o, wc_o, bus_addr_o, csr_ext_o and disk_addr_o are all zero.
- R2: start_i is accepted only while busy_o is low. busy_o is high from the cycle after the accepting edge. done_o rises for exactly one cycle, 18 clock edges after the accepting edge with the default serial divider (1 edge with the direct divider), and busy_o is low whenever done_o is high. A start_i pulse while busy_o is high changes neither the timing nor the results.
- R3: The requested length is 65536 minus wc_reg_i, so a register value of 0 requests 65536 words. The applied length is the smaller of words_moved_i and the allowed length from R6. wc_o equals (wc_reg_i + applied) mod 65536.
- R4: The start memory address is the 18-bit value {csr_ext_i, bus_addr_i} with bus-address bit 0 forced to 0. Without inhibit, the result is that address plus 2 × applied, taken mod 2^18. bus_addr_o carries the low 16 bits, with bit 0 always 0, and csr_ext_o carries the upper 2 bits.
- R5: With inhibit_i high, the returned memory address equals the start memory address (bit 0 still cleared), whatever the length.
- R6: The start offset is (track × 12 + sector) × 256 words. The track is disk_addr_i[12:4] and the sector is disk_addr_i[3:0]. The drive holds 1,247,232 words. The room is the capacity minus the offset, or 0 when the offset is at or past the capacity. If the requested length exceeds the room, the allowed length is the room and overrun_o is 1. Otherwise the allowed length is the requested length and overrun_o is 0.
- R7: In a normal transfer (fmt_read_i low), the end word position is offset + applied + 255, and the new linear sector is that position divided by 256, rounded down.
- R8: In a format-read transfer (fmt_read_i high), the end word position is offset + applied × 256.
- R9: disk_addr_o[15:13] repeats the drive field of disk_addr_i. disk_addr_o[12:4] is (linear / 12) mod 512 and disk_addr_o[3:0] is linear mod 12.
- R10: After done_o, wc_o, bus_addr_o, csr_ext_o, disk_addr_o and overrun_o hold their values until another start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load operands and begin an update |
| csr_ext_i | input | 2 | Memory-address extension bits (address bits 17:16) |
| bus_addr_i | input | 16 | Start bus address; bit 0 ignored |
| wc_reg_i | input | 16 | Word-count register (two's complement of length) |
| disk_addr_i | input | 16 | Packed drive, track and sector at start |
| words_moved_i | input | 17 | Words the data path moved |
| inhibit_i | input | 1 | Keep the memory address fixed |
| fmt_read_i | input | 1 | Format-read sector counting |
| done_o | output | 1 | One-cycle pulse: results valid |
| busy_o | output | 1 | Update in progress |
| wc_o | output | 16 | Final word-count register value |
| bus_addr_o | output | 16 | Final bus address, bit 0 zero |
| csr_ext_o | output | 2 | Final address extension bits |
| disk_addr_o | output | 16 | Disk address of the next sector |
| overrun_o | output | 1 | Request ran past the end of the drive |

## Verification
The word count, memory address and overrun flag are registered one edge after the accepting edge. The disk address settles only when the divider finishes, and done_o rises 18 edges after acceptance. The bench drives start on a falling edge and counts rising edges from the accepting edge. At each falling edge before the due edge it confirms that done_o is still low. At the falling edge just after the due edge it compares every result with values it computes arithmetically, and one cycle later it checks that done_o has dropped. For the ignored-start and hold cases, it then watches for a further twenty cycles to confirm that no second done pulse appears and no output changes.

// File: rtl/xpu_pkg.sv
package xpu_pkg;

   typedef enum logic [1:0] {
      XPU_IDLE = 2'd0,
      XPU_CALC = 2'd1,
      XPU_WAIT = 2'd2
   } xpu_state_e;

   localparam int XPU_DIV_SERIAL = 0;
   localparam int XPU_DIV_DIRECT = 1;

endpackage

// File: rtl/xpu_span.sv
module xpu_span #(
   parameter int WC_W  = 16,
   parameter int LIN_W = 17,
   parameter int WPS_W = 8,
   parameter int CAP   = 1247232
) (
   input  logic [LIN_W-1:0]  lin_start_i,
   input  logic [WC_W-1:0]   wc_reg_i,
   input  logic [WC_W:0]     moved_i,
   input  logic              fmt_i,
   output logic [WC_W:0]     applied_o,
   output logic              overrun_o,
   output logic [LIN_W-1:0]  lin_next_o
);
   localparam int CNT_W = WC_W + 1;
   localparam int POS_W = LIN_W + WPS_W;

   logic [POS_W-1:0] offset;
   logic [POS_W-1:0] room;
   logic [POS_W-1:0] req_w;
   logic [POS_W-1:0] applied_w;
   logic [POS_W-1:0] pos;
   logic [CNT_W-1:0] req;
   logic [CNT_W-1:0] allowed;
   logic             unused_pos;

   always_comb begin
      offset    = {lin_start_i, {WPS_W{1'b0}}};
      room      = (offset >= POS_W'(CAP)) ? '0 : POS_W'(CAP) - offset;
      req       = {1'b1, {WC_W{1'b0}}} - {1'b0, wc_reg_i};
      req_w     = POS_W'(req);
      overrun_o = req_w > room;
      allowed   = overrun_o ? room[CNT_W-1:0] : req;
      applied_o = (moved_i > allowed) ? allowed : moved_i;
      applied_w = POS_W'(applied_o);
      if (fmt_i)
         pos = offset + (applied_w << WPS_W);
      else
         pos = offset + applied_w + POS_W'((2 ** WPS_W) - 1);
      lin_next_o = pos[POS_W-1:WPS_W];
   end

   assign unused_pos = ^pos[WPS_W-1:0];

endmodule

// File: rtl/xpu_mem_advance.sv
module xpu_mem_advance #(
   parameter int WC_W  = 16,
   parameter int EXT_W = 2
) (
   input  logic [EXT_W-1:0] ext_i,
   input  logic [WC_W-1:0]  ba_i,
   input  logic [WC_W-1:0]  wc_reg_i,
   input  logic [WC_W:0]    applied_i,
   input  logic             inhibit_i,
   output logic [EXT_W-1:0] ext_o,
   output logic [WC_W-1:0]  ba_o,
   output logic [WC_W-1:0]  wc_o
);
   localparam int MA_W  = WC_W + EXT_W;
   localparam int SUM_W = MA_W + WC_W + 2;

   logic [SUM_W-1:0] base;
   logic [SUM_W-1:0] step;
   logic [SUM_W-1:0] sum;
   logic             unused_bits;

   always_comb begin
      base = SUM_W'({ext_i, ba_i[WC_W-1:1], 1'b0});
      step = inhibit_i ? '0 : SUM_W'({applied_i, 1'b0});
      sum  = base + step;
      ba_o  = sum[WC_W-1:0];
      ext_o = sum[MA_W-1:WC_W];
      wc_o  = wc_reg_i + applied_i[WC_W-1:0];
   end

   assign unused_bits = ^{sum[SUM_W-1:MA_W], ba_i[0], applied_i[WC_W]};

endmodule

// File: rtl/xpu_div_const.sv
module xpu_div_const #(
   parameter int W       = 17,
   parameter int DIVISOR = 12,
   parameter int STYLE   = 0
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         load_i,
   input  logic [W-1:0]                 dividend_i,
   output logic [W-1:0]                 quo_o,
   output logic [$clog2(DIVISOR)-1:0]   rem_o,
   output logic                         done_o,
   output logic                         finishing_o
);
   import xpu_pkg::*;

   localparam int R_W = $clog2(DIVISOR);
   localparam int C_W = $clog2(W + 1);
   localparam int E_W = W + R_W + 1;

   logic [W-1:0]   quo_q;
   logic [R_W-1:0] rem_q;
   logic [W-1:0]   dvd_q;
   logic           done_q;

   if (W < 2) begin : g_bad_width
      $error("xpu_div_const: W must be at least 2");
   end
   if (DIVISOR < 2) begin : g_bad_divisor
      $error("xpu_div_const: DIVISOR must be at least 2");
   end

   if (STYLE == XPU_DIV_SERIAL) begin : g_serial
      logic [C_W-1:0] cnt;
      logic [R_W:0]   trial;
      logic [R_W:0]   diff;
      logic           fits;

      assign trial = {rem_q, quo_q[W-1]};
      assign fits  = trial >= (R_W + 1)'(DIVISOR);
      assign diff  = trial - (R_W + 1)'(DIVISOR);
      assign finishing_o = (cnt == C_W'(1));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            quo_q  <= '0;
            rem_q  <= '0;
            dvd_q  <= '0;
            cnt    <= '0;
            done_q <= 1'b0;
         end else begin
            done_q <= 1'b0;
            if (load_i) begin
               quo_q <= dividend_i;
               rem_q <= '0;
               dvd_q <= dividend_i;
               cnt   <= C_W'(W);
            end else if (cnt != '0) begin
               quo_q <= {quo_q[W-2:0], fits};
               rem_q <= fits ? diff[R_W-1:0] : trial[R_W-1:0];
               cnt   <= cnt - C_W'(1);
               if (cnt == C_W'(1))
                  done_q <= 1'b1;
            end
         end
      end
   end else begin : g_direct
      assign finishing_o = load_i;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            quo_q  <= '0;
            rem_q  <= '0;
            dvd_q  <= '0;
            done_q <= 1'b0;
         end else begin
            done_q <= load_i;
            if (load_i) begin
               quo_q <= dividend_i / W'(DIVISOR);
               rem_q <= R_W'(dividend_i % W'(DIVISOR));
               dvd_q <= dividend_i;
            end
         end
      end
   end

   assign quo_o  = quo_q;
   assign rem_o  = rem_q;
   assign done_o = done_q;

   // R9: the remainder register never reaches the divisor
   assert_rem_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
      {1'b0, rem_q} < (R_W + 1)'(DIVISOR));

   // R9: at completion quotient and remainder rebuild the loaded dividend
   assert_div_exact_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (E_W'(quo_q) * E_W'(DIVISOR) + E_W'(rem_q) == E_W'(dvd_q)));

endmodule

// File: rtl/xfer_pos_updater.sv
module xfer_pos_updater #(
   parameter int DA_W      = 16,
   parameter int SEC_W     = 4,
   parameter int TRK_W     = 9,
   parameter int WC_W      = 16,
   parameter int EXT_W     = 2,
   parameter int CYLS      = 203,
   parameter int HEADS     = 2,
   parameter int SECTS     = 12,
   parameter int WPS       = 256,
   parameter int DIV_STYLE = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [EXT_W-1:0]   csr_ext_i,
   input  logic [WC_W-1:0]    bus_addr_i,
   input  logic [WC_W-1:0]    wc_reg_i,
   input  logic [DA_W-1:0]    disk_addr_i,
   input  logic [WC_W:0]      words_moved_i,
   input  logic               inhibit_i,
   input  logic               fmt_read_i,
   output logic               done_o,
   output logic               busy_o,
   output logic [WC_W-1:0]    wc_o,
   output logic [WC_W-1:0]    bus_addr_o,
   output logic [EXT_W-1:0]   csr_ext_o,
   output logic [DA_W-1:0]    disk_addr_o,
   output logic               overrun_o
);
   import xpu_pkg::*;

   localparam int WPS_W = $clog2(WPS);
   localparam int CAP   = CYLS * HEADS * SECTS * WPS;
   localparam int LIN_W = $clog2((2 ** TRK_W) * SECTS + (2 ** WC_W) + 1);
   localparam int R_W   = $clog2(SECTS);
   localparam int FLD_W = SEC_W + TRK_W;
   localparam int DRV_W = DA_W - FLD_W;

   if ((2 ** WPS_W) != WPS) begin : g_bad_wps
      $error("xfer_pos_updater: WPS must be a power of two");
   end
   if (SECTS > (2 ** SEC_W)) begin : g_bad_sects
      $error("xfer_pos_updater: SECTS does not fit the sector field");
   end
   if (DRV_W < 1) begin : g_bad_fields
      $error("xfer_pos_updater: no room for the drive field");
   end
   if (LIN_W < TRK_W) begin : g_bad_lin
      $error("xfer_pos_updater: linear width below track width");
   end

   xpu_state_e       state;
   logic [EXT_W-1:0] ext_q;
   logic [WC_W-1:0]  ba_q;
   logic [WC_W-1:0]  wc_q;
   logic [DA_W-1:0]  da_q;
   logic [WC_W:0]    moved_q;
   logic             inh_q;
   logic             fmt_q;

   logic [LIN_W-1:0] lin_start;
   logic [LIN_W-1:0] lin_next;
   logic [WC_W:0]    applied;
   logic             overrun_c;
   logic [EXT_W-1:0] ext_c;
   logic [WC_W-1:0]  ba_c;
   logic [WC_W-1:0]  wc_c;
   logic [LIN_W-1:0] quo;
   logic [R_W-1:0]   rem;
   logic             div_done;
   logic             div_finishing;
   logic             div_load;
   logic             unused_quo;

   always_comb begin
      lin_start = LIN_W'(da_q[FLD_W-1:SEC_W]) * LIN_W'(SECTS)
                + LIN_W'(da_q[SEC_W-1:0]);
   end

   xpu_span #(
      .WC_W  (WC_W),
      .LIN_W (LIN_W),
      .WPS_W (WPS_W),
      .CAP   (CAP)
   ) u_span (
      .lin_start_i (lin_start),
      .wc_reg_i    (wc_q),
      .moved_i     (moved_q),
      .fmt_i       (fmt_q),
      .applied_o   (applied),
      .overrun_o   (overrun_c),
      .lin_next_o  (lin_next)
   );

   xpu_mem_advance #(
      .WC_W  (WC_W),
      .EXT_W (EXT_W)
   ) u_mem (
      .ext_i     (ext_q),
      .ba_i      (ba_q),
      .wc_reg_i  (wc_q),
      .applied_i (applied),
      .inhibit_i (inh_q),
      .ext_o     (ext_c),
      .ba_o      (ba_c),
      .wc_o      (wc_c)
   );

   assign div_load = (state == XPU_CALC);

   xpu_div_const #(
      .W       (LIN_W),
      .DIVISOR (SECTS),
      .STYLE   (DIV_STYLE)
   ) u_div (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (div_load),
      .dividend_i  (lin_next),
      .quo_o       (quo),
      .rem_o       (rem),
      .done_o      (div_done),
      .finishing_o (div_finishing)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= XPU_IDLE;
         ext_q      <= '0;
         ba_q       <= '0;
         wc_q       <= '0;
         da_q       <= '0;
         moved_q    <= '0;
         inh_q      <= 1'b0;
         fmt_q      <= 1'b0;
         wc_o       <= '0;
         bus_addr_o <= '0;
         csr_ext_o  <= '0;
         overrun_o  <= 1'b0;
      end else begin
         case (state)
            XPU_IDLE: begin
               if (start_i) begin
                  ext_q   <= csr_ext_i;
                  ba_q    <= bus_addr_i;
                  wc_q    <= wc_reg_i;
                  da_q    <= disk_addr_i;
                  moved_q <= words_moved_i;
                  inh_q   <= inhibit_i;
                  fmt_q   <= fmt_read_i;
                  state   <= XPU_CALC;
               end
            end
            XPU_CALC: begin
               wc_o       <= wc_c;
               bus_addr_o <= ba_c;
               csr_ext_o  <= ext_c;
               overrun_o  <= overrun_c;
               state      <= div_finishing ? XPU_IDLE : XPU_WAIT;
            end
            XPU_WAIT: begin
               if (div_finishing)
                  state <= XPU_IDLE;
            end
            default: state <= XPU_IDLE;
         endcase
      end
   end

   assign disk_addr_o = {da_q[DA_W-1:FLD_W], quo[TRK_W-1:0], SEC_W'(rem)};
   assign done_o      = div_done;
   assign busy_o      = (state != XPU_IDLE);
   assign unused_quo  = ^quo[LIN_W-1:TRK_W];

   // R2: done is a single-cycle pulse
   assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R2: the unit is idle again when results are announced
   assert_idle_on_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   // R4: the returned bus address is always word aligned
   assert_even_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
      bus_addr_o[0] == 1'b0);

   // R5: inhibit leaves the memory address where it started
   assert_inhibit_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && inh_q) |-> ({csr_ext_o, bus_addr_o} == {ext_q, ba_q[WC_W-1:1], 1'b0}));

   // R9: the drive field passes through from the loaded address
   assert_drive_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (disk_addr_o[DA_W-1:FLD_W] == da_q[DA_W-1:FLD_W]));

   // R10: results stay put while idle and no start arrives
   assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> ($stable(wc_o) && $stable(bus_addr_o) &&
                                 $stable(csr_ext_o) && $stable(disk_addr_o) &&
                                 $stable(overrun_o)));

endmodule

// File: tb/xfer_pos_updater_test.sv
`timescale 1ns/1ps
module xfer_pos_updater_test;

   localparam int  LAT = 18;
   localparam longint CAP = 203 * 2 * 12 * 256;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [1:0]  csr_ext_i = '0;
   logic [15:0] bus_addr_i = '0;
   logic [15:0] wc_reg_i = '0;
   logic [15:0] disk_addr_i = '0;
   logic [16:0] words_moved_i = '0;
   logic        inhibit_i = 1'b0;
   logic        fmt_read_i = 1'b0;
   logic        done_o, busy_o, overrun_o;
   logic [15:0] wc_o, bus_addr_o, disk_addr_o;
   logic [1:0]  csr_ext_o;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   xfer_pos_updater uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .start_i       (start_i),
      .csr_ext_i     (csr_ext_i),
      .bus_addr_i    (bus_addr_i),
      .wc_reg_i      (wc_reg_i),
      .disk_addr_i   (disk_addr_i),
      .words_moved_i (words_moved_i),
      .inhibit_i     (inhibit_i),
      .fmt_read_i    (fmt_read_i),
      .done_o        (done_o),
      .busy_o        (busy_o),
      .wc_o          (wc_o),
      .bus_addr_o    (bus_addr_o),
      .csr_ext_o     (csr_ext_o),
      .disk_addr_o   (disk_addr_o),
      .overrun_o     (overrun_o)
   );

   task automatic chk(input string rq, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   task automatic run_op(input int ext, input int ba, input int wc, input int da,
                         input int moved, input bit inh, input bit fmt, input bit poke);
      longint req, off, room, allowed, app, ma, pos, lin, e_da;
      bit     ovr, early;
      logic [15:0] s_wc, s_ba, s_da;
      logic [1:0]  s_ext;
      logic        s_ovr;
      bit          moved_out, extra;
      req  = 65536 - wc;
      off  = (longint'((da >> 4) & 511) * 12 + (da & 15)) * 256;
      room = (off >= CAP) ? 0 : CAP - off;
      ovr  = req > room;
      allowed = ovr ? room : req;
      app  = (moved > allowed) ? allowed : moved;
      ma   = (longint'(ext) << 16) | (ba & 16'hFFFE);
      if (!inh) ma = (ma + 2 * app) % 262144;
      pos  = fmt ? off + app * 256 : off + app + 255;
      lin  = pos / 256;
      e_da = (da & 16'hE000) | (((lin / 12) % 512) << 4) | (lin % 12);

      @(negedge clk);
      csr_ext_i = 2'(ext); bus_addr_i = 16'(ba); wc_reg_i = 16'(wc);
      disk_addr_i = 16'(da); words_moved_i = 17'(moved);
      inhibit_i = inh; fmt_read_i = fmt; start_i = 1'b1;
      @(posedge clk);
      early = 0;
      for (int k = 1; k <= LAT; k++) begin
         @(negedge clk);
         if (done_o) early = 1;
         if (k == 1) chk("R2", "busy after accept", busy_o, 1);
         if (poke && k == 3) begin
            start_i = 1'b1; disk_addr_i = ~16'(da); wc_reg_i = 16'(wc) ^ 16'h5555;
            words_moved_i = 17'd3; inhibit_i = ~inh;
         end else start_i = 1'b0;
         @(posedge clk);
      end
      @(negedge clk);
      start_i = 1'b0;
      chk("R2", "done not early", early, 0);
      chk("R2", "done on time", done_o, 1);
      chk("R2", "idle at done", busy_o, 0);
      chk("R3", "word count", wc_o, (wc + app) % 65536);
      chk(inh ? "R5" : "R4", "bus address", bus_addr_o, ma & 16'hFFFF);
      chk(inh ? "R5" : "R4", "extension", csr_ext_o, ma >> 16);
      chk("R6", "overrun", overrun_o, ovr);
      chk(fmt ? "R8" : "R7", "disk address", disk_addr_o, e_da);
      chk("R9", "drive field", disk_addr_o[15:13], (da >> 13) & 7);
      @(negedge clk);
      chk("R2", "done one cycle", done_o, 0);
      if (poke) begin
         s_wc = wc_o; s_ba = bus_addr_o; s_da = disk_addr_o; s_ext = csr_ext_o; s_ovr = overrun_o;
         moved_out = 0; extra = 0;
         for (int k = 0; k < LAT + 2; k++) begin
            @(negedge clk);
            if (done_o) extra = 1;
            if (wc_o != s_wc || bus_addr_o != s_ba || disk_addr_o != s_da ||
                csr_ext_o != s_ext || overrun_o != s_ovr) moved_out = 1;
         end
         chk("R2", "no done from ignored start", extra, 0);
         chk("R10", "outputs held", moved_out, 0);
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int trk_list [6] = '{0, 1, 5, 405, 406, 511};
      int sec_list [5] = '{0, 1, 11, 12, 15};
      int wc_list  [5] = '{16'hFF00, 16'hFFFF, 16'h0000, 16'hFE01, 16'h8000};
      int idx;
      repeat (3) @(negedge clk);
      chk("R1", "done in reset", done_o, 0);
      chk("R1", "busy in reset", busy_o, 0);
      chk("R1", "outputs in reset", {wc_o, bus_addr_o, csr_ext_o, disk_addr_o, overrun_o}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1", "idle after reset", {done_o, busy_o}, 0);
      chk("R1", "outputs after reset", {wc_o, bus_addr_o, csr_ext_o, disk_addr_o, overrun_o}, 0);

      // R2 / R10: start pulses while busy are ignored, results then hold
      run_op(1, 16'h1234, 16'hFF00, 16'h2015, 256, 0, 0, 1);
      run_op(3, 16'hFFFE, 16'h0000, 16'hE000 | (405 << 4), 65536, 0, 1, 1);

      idx = 0;
      foreach (trk_list[t]) foreach (sec_list[s]) foreach (wc_list[w])
         for (int mv = 0; mv < 3; mv++)
            for (int mode = 0; mode < 4; mode++) begin
               int rq, mvv;
               rq  = 65536 - wc_list[w];
               mvv = (mv == 0) ? rq : (mv == 1) ? 0 : 257;
               run_op(idx % 4, (idx * 16'h1F3D + 16'h0101) & 16'hFFFF, wc_list[w],
                      ((idx % 8) << 13) | (trk_list[t] << 4) | sec_list[s],
                      mvv, mode[0], mode[1], 0);
               idx++;
            end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule